// File: doc/BRIEF.md
# Vector Unit Configuration Register

This block holds the configuration state of a vector coprocessor. A single configure command carries an 8-bit immediate. That one command sets several fields at once and also has side effects: it selects the highest enabled vector register, the maximum element width and the clip mode. It forces the rounding mode back to its default and reloads the vector length with the machine maximum. When the register field of the immediate is zero, the command switches the unit off.

Software can adjust the 2-bit rounding mode afterwards through a set-bits port, which ORs bits into the field. It can also shorten the vector length through a direct write, which is clamped to the machine maximum. Every field is write-any, read-legal: a width code the implementation cannot hold is turned into the widest code it can hold.

Control is a two-state machine. The states are `ST_OFF` (unit disabled) and `ST_ON` (unit enabled). There are two transitions:
- `CFG_ENABLE` is a configure command with a non-zero register field. It goes from either state to `ST_ON`.
- `CFG_DISABLE` is a configure command with a zero register field. It goes from either state to `ST_OFF`.

Any other cycle keeps the current state. Every output is registered, so it changes on the clock edge that samples the command.

Top module: `vcfg_regs`

## Requirements
- R1: After reset the outputs are: `unit_en` 0, `vreg_high` 0, `elem_width` 3'b001, `clip_mode` 0, `round_mode` 2'b10 and `vl` 0.
- R2: A configure command whose `cfg_imm[4:0]` is N, with N not zero, sets `unit_en` to 1 and `vreg_high` to N, meaning registers 0..N are enabled. `vreg_high` never exceeds 31.
- R3: A configure command with `cfg_imm[4:0]` = 0 clears `unit_en`, `vreg_high` and `vl`. This includes the all-zero immediate.
- R4: A configure command stores `{1'b0, cfg_imm[6:5]}` in `elem_width` when the code is supported. The codes are 01 = 8 bits, 10 = 16 bits, 11 = 32 bits and 00 = 64 bits.
- R5: A width code wider than MAX_ELEM_BITS is stored as the widest supported code. With the default of 32, code 00 is stored as 3'b011.
- R6: A configure command copies `cfg_imm[7]` into `clip_mode`.
- R7: A configure command sets `round_mode` to 2'b10. A set-bits command ORs `rm_set_bits` into `round_mode`. When both arrive in the same cycle, the bits are ORed onto 2'b10.
- R8: A configure command that enables the unit sets `vl` to MAXVL (default 8).
- R9: A vector-length write while the unit is enabled stores `vl_wr_data`, clamped to MAXVL.
- R10: A vector-length write is ignored while the unit is disabled, so `vl` stays 0. A configure command in the same cycle as a vector-length write takes precedence over it.
- R11: In a cycle with no command, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configure command strobe |
| cfg_imm | input | 8 | Configure immediate: [4:0] highest register, [6:5] width code, [7] clip mode |
| rm_set_valid | input | 1 | Rounding-mode set-bits strobe |
| rm_set_bits | input | 2 | Bits ORed into the rounding mode |
| vl_wr_valid | input | 1 | Direct vector-length write strobe |
| vl_wr_data | input | $clog2(MAXVL+1) | Requested vector length |
| unit_en | output | 1 | Vector unit enabled |
| vreg_high | output | 8 | Highest enabled vector register number |
| elem_width | output | 3 | Legalized maximum element width code |
| clip_mode | output | 1 | Fixed-point clip mode |
| round_mode | output | 2 | Fixed-point rounding mode |
| vl | output | $clog2(MAXVL+1) | Current vector length |

## Verification
The assertions assume that the strobes are never unknown after reset. They also assume that `vl_wr_data` may carry any value of its width, including values above MAXVL, so clamping is exercised rather than assumed. The hold property takes it for granted that a cycle with all three strobes low carries no command.

The bench drives commands one per cycle on the falling edge. It covers every width code, the zero and maximum register fields, and coincident command pairs. It drives over-range vector lengths on purpose and keeps all strobes low in idle cycles.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } vcfg_state_e;

    localparam logic [1:0] RM_DEFAULT   = 2'b10;
    localparam logic [7:0] VREG_HIGHEST = 8'd31;

    // element bits represented by a 2-bit width code
    function automatic int unsigned code_bits(input logic [1:0] code);
        unique case (code)
            2'b01:   code_bits = 8;
            2'b10:   code_bits = 16;
            2'b11:   code_bits = 32;
            default: code_bits = 64;
        endcase
    endfunction

    // widest code not exceeding the supported element size
    function automatic logic [1:0] widest_code(input int unsigned max_bits);
        if (max_bits >= 64)      widest_code = 2'b00;
        else if (max_bits >= 32) widest_code = 2'b11;
        else if (max_bits >= 16) widest_code = 2'b10;
        else                     widest_code = 2'b01;
    endfunction

    function automatic logic [7:0] legal_high(input logic [7:0] req);
        legal_high = (req > VREG_HIGHEST) ? VREG_HIGHEST : req;
    endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int unsigned MAX_ELEM_BITS = 32
) (
    input  logic [7:0] imm,
    output logic [7:0] dec_high,
    output logic [2:0] dec_width,
    output logic       dec_clip,
    output logic       dec_turn_on
);
    localparam logic [1:0] TOP_CODE = widest_code(MAX_ELEM_BITS);

    logic [1:0] raw_code;

    always_comb begin
        raw_code    = imm[6:5];
        dec_high    = legal_high({3'b000, imm[4:0]});
        dec_turn_on = (dec_high != 8'd0);
        dec_clip    = imm[7];
        if (code_bits(raw_code) > MAX_ELEM_BITS)
            dec_width = {1'b0, TOP_CODE};
        else
            dec_width = {1'b0, raw_code};
    end
endmodule

// File: rtl/vcfg_fsm.sv
module vcfg_fsm
    import vcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_valid,
    input  logic [7:0] dec_high,
    input  logic [2:0] dec_width,
    input  logic       dec_clip,
    input  logic       dec_turn_on,
    output logic       unit_en,
    output logic [7:0] vreg_high,
    output logic [2:0] elem_width,
    output logic       clip_mode
);
    vcfg_state_e state_q, state_d;
    logic [7:0]  high_q;
    logic [2:0]  width_q;
    logic        clip_q;

    // next-state selection: CFG_ENABLE / CFG_DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cfg_valid && dec_turn_on)  state_d = ST_ON;
            ST_ON:  if (cfg_valid && !dec_turn_on) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // configuration fields captured by a configure command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_q  <= 8'd0;
            width_q <= 3'b001;
            clip_q  <= 1'b0;
        end else if (cfg_valid) begin
            high_q  <= dec_high;
            width_q <= dec_width;
            clip_q  <= dec_clip;
        end
    end

    // outputs
    always_comb begin
        unit_en    = (state_q == ST_ON);
        vreg_high  = high_q;
        elem_width = width_q;
        clip_mode  = clip_q;
    end
endmodule

// File: rtl/vcfg_round.sv
module vcfg_round
    import vcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_valid,
    input  logic       rm_set_valid,
    input  logic [1:0] rm_set_bits,
    output logic [1:0] round_mode
);
    logic [1:0] rm_q, rm_base, rm_d;

    always_comb begin
        rm_base = cfg_valid ? RM_DEFAULT : rm_q;
        rm_d    = rm_set_valid ? (rm_base | rm_set_bits) : rm_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rm_q <= RM_DEFAULT;
        else        rm_q <= rm_d;
    end

    assign round_mode = rm_q;
endmodule

// File: rtl/vcfg_vlen.sv
module vcfg_vlen #(
    parameter int unsigned MAXVL = 8,
    localparam int unsigned VLW  = $clog2(MAXVL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_valid,
    input  logic           dec_turn_on,
    input  logic           unit_en,
    input  logic           vl_wr_valid,
    input  logic [VLW-1:0] vl_wr_data,
    output logic [VLW-1:0] vl
);
    localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

    logic [VLW-1:0] vl_q, vl_d, wr_clamped;

    always_comb begin
        wr_clamped = (vl_wr_data > VL_MAX) ? VL_MAX : vl_wr_data;
        vl_d       = vl_q;
        if (cfg_valid)
            vl_d = dec_turn_on ? VL_MAX : '0;
        else if (vl_wr_valid && unit_en)
            vl_d = wr_clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vl_q <= '0;
        else        vl_q <= vl_d;
    end

    assign vl = unit_en ? vl_q : '0;
endmodule

// File: rtl/vcfg_regs.sv
module vcfg_regs #(
    parameter int unsigned MAXVL         = 8,
    parameter int unsigned MAX_ELEM_BITS = 32,
    localparam int unsigned VLW          = $clog2(MAXVL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_valid,
    input  logic [7:0]     cfg_imm,
    input  logic           rm_set_valid,
    input  logic [1:0]     rm_set_bits,
    input  logic           vl_wr_valid,
    input  logic [VLW-1:0] vl_wr_data,
    output logic           unit_en,
    output logic [7:0]     vreg_high,
    output logic [2:0]     elem_width,
    output logic           clip_mode,
    output logic [1:0]     round_mode,
    output logic [VLW-1:0] vl
);
    logic [7:0] dec_high;
    logic [2:0] dec_width;
    logic       dec_clip;
    logic       dec_turn_on;

    vcfg_decode #(.MAX_ELEM_BITS(MAX_ELEM_BITS)) u_decode (
        .imm         (cfg_imm),
        .dec_high    (dec_high),
        .dec_width   (dec_width),
        .dec_clip    (dec_clip),
        .dec_turn_on (dec_turn_on)
    );

    vcfg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .dec_high    (dec_high),
        .dec_width   (dec_width),
        .dec_clip    (dec_clip),
        .dec_turn_on (dec_turn_on),
        .unit_en     (unit_en),
        .vreg_high   (vreg_high),
        .elem_width  (elem_width),
        .clip_mode   (clip_mode)
    );

    vcfg_round u_round (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .rm_set_valid (rm_set_valid),
        .rm_set_bits  (rm_set_bits),
        .round_mode   (round_mode)
    );

    vcfg_vlen #(.MAXVL(MAXVL)) u_vlen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .dec_turn_on (dec_turn_on),
        .unit_en     (unit_en),
        .vl_wr_valid (vl_wr_valid),
        .vl_wr_data  (vl_wr_data),
        .vl          (vl)
    );
endmodule

// File: rtl/vcfg_regs_chk.sv
module vcfg_regs_chk #(
    parameter int unsigned MAXVL         = 8,
    parameter int unsigned MAX_ELEM_BITS = 32,
    localparam int unsigned VLW          = $clog2(MAXVL + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_valid,
    input logic [7:0]     cfg_imm,
    input logic           rm_set_valid,
    input logic [1:0]     rm_set_bits,
    input logic           vl_wr_valid,
    input logic [VLW-1:0] vl_wr_data,
    input logic           unit_en,
    input logic [7:0]     vreg_high,
    input logic [2:0]     elem_width,
    input logic           clip_mode,
    input logic [1:0]     round_mode,
    input logic [VLW-1:0] vl
);
    localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

    logic width_ok;
    always_comb width_ok = (elem_width[2] == 1'b0) &&
                           (vcfg_pkg::code_bits(elem_width[1:0]) <= MAX_ELEM_BITS);

    AST_VREG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_high <= 8'd31);  // R2
    AST_CFG_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_imm[4:0] != 5'd0) |=> (unit_en && vreg_high == $past({3'b000, cfg_imm[4:0]})));  // R2
    AST_CFG_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_imm[4:0] == 5'd0) |=> (!unit_en && vl == '0));  // R3
    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        width_ok);  // R5
    AST_CLIP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (clip_mode == $past(cfg_imm[7])));  // R6
    AST_CFG_RM_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !rm_set_valid) |=> (round_mode == 2'b10));  // R7
    AST_CFG_VL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_imm[4:0] != 5'd0) |=> (vl == VL_MAX));  // R8
    AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vl <= VL_MAX);  // R9
    AST_OFF_VL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> (vl == '0));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid && !rm_set_valid && !vl_wr_valid) |=>
        $stable({unit_en, vreg_high, elem_width, clip_mode, round_mode, vl}));  // R11
endmodule

bind vcfg_regs vcfg_regs_chk #(.MAXVL(MAXVL), .MAX_ELEM_BITS(MAX_ELEM_BITS)) u_chk (.*);

// File: tb/vcfg_regs_test.sv
module vcfg_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXVL      = 8;
    localparam int MAXELEM    = 32;
    localparam int VLW        = $clog2(MAXVL + 1);
    localparam int EXPW       = 1 + 8 + 3 + 1 + 2 + VLW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_valid = 1'b0;
    logic [7:0]     cfg_imm = 8'd0;
    logic           rm_set_valid = 1'b0;
    logic [1:0]     rm_set_bits = 2'b00;
    logic           vl_wr_valid = 1'b0;
    logic [VLW-1:0] vl_wr_data = '0;
    logic           unit_en;
    logic [7:0]     vreg_high;
    logic [2:0]     elem_width;
    logic           clip_mode;
    logic [1:0]     round_mode;
    logic [VLW-1:0] vl;

    int checks = 0;
    int fails  = 0;
    logic [EXPW-1:0] exp_q[$];
    string           tag_q[$];

    // reference model state
    logic           m_en = 1'b0;
    logic [7:0]     m_high = 8'd0;
    logic [2:0]     m_ew = 3'b001;
    logic           m_clip = 1'b0;
    logic [1:0]     m_rm = 2'b10;
    logic [VLW-1:0] m_vl = '0;

    vcfg_regs #(.MAXVL(MAXVL), .MAX_ELEM_BITS(MAXELEM)) uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int bits_of(input logic [1:0] c);
        case (c)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [EXPW-1:0] observed();
        return {unit_en, vreg_high, elem_width, clip_mode, round_mode, vl};
    endfunction

    task automatic compare(input logic [EXPW-1:0] exp, input string tag);
        checks++;
        if (observed() !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, observed(), exp);
        end
    endtask

    task automatic op(input logic cv, input logic [7:0] imm, input logic rv,
                      input logic [1:0] rb, input logic wv, input logic [VLW-1:0] wd,
                      input string tag);
        logic [1:0] code;
        @(negedge clk);
        cfg_valid = cv; cfg_imm = imm; rm_set_valid = rv; rm_set_bits = rb;
        vl_wr_valid = wv; vl_wr_data = wd;
        if (cv) begin
            m_high = {3'b000, imm[4:0]};
            m_en   = (imm[4:0] != 5'd0);
            code   = imm[6:5];
            if (bits_of(code) > MAXELEM) code = 2'b11;
            m_ew   = {1'b0, code};
            m_clip = imm[7];
            m_rm   = 2'b10;
            m_vl   = m_en ? VLW'(MAXVL) : '0;
        end else if (wv && m_en) begin
            m_vl = (int'(wd) > MAXVL) ? VLW'(MAXVL) : wd;
        end
        if (rv) m_rm = m_rm | rb;
        exp_q.push_back({m_en, m_high, m_ew, m_clip, m_rm, m_vl});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b0, '0, tag);
    endtask

    // monitor: each registered result appears one edge after its command
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare({1'b0, 8'd0, 3'b001, 1'b0, 2'b10, VLW'(0)}, "R1 reset state");

        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd5, "R10 vl write while off");
        op(1'b1, 8'h63, 1'b0, 2'b00, 1'b0, '0, "R2 R4 R8 cfg 4 regs 32b");
        idle("R11 hold after cfg");
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd5, "R9 vl write 5");
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd12, "R9 vl write clamp 12");
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd0, "R9 vl write 0");
        op(1'b0, 8'd0, 1'b1, 2'b01, 1'b0, '0, "R7 set bits 01");
        op(1'b1, 8'h9F, 1'b0, 2'b00, 1'b0, '0, "R5 R6 R7 cfg 32 regs w64 clip");
        op(1'b1, 8'h21, 1'b0, 2'b00, 1'b0, '0, "R2 R4 cfg 2 regs 8b");
        op(1'b1, 8'h45, 1'b1, 2'b01, 1'b0, '0, "R7 cfg with set bits");
        op(1'b1, 8'h42, 1'b0, 2'b00, 1'b1, 4'd3, "R10 cfg beats vl write");
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd8, "R9 vl write max");
        op(1'b1, 8'h80, 1'b0, 2'b00, 1'b0, '0, "R3 R6 cfg zero regs");
        op(1'b0, 8'd0, 1'b0, 2'b00, 1'b1, 4'd7, "R10 vl write after off");
        op(1'b1, 8'h00, 1'b1, 2'b11, 1'b0, '0, "R3 R7 cfg all zero");
        idle("R11 hold while off");
        op(1'b1, 8'h7F, 1'b0, 2'b00, 1'b0, '0, "R2 R8 cfg re-enable");
        idle("R11 final hold");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule